// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block sits between the logic that decides which SDRAM command to send next and the pins of the memory device. An upstream issuer presents one request at a time: an operation code, a bank number and a valid strobe. The gate checks whether that command is legal for the current state of the target bank and whether every minimum spacing that applies to it has elapsed. If the command is legal and its spacing has elapsed, the gate grants it and drives it to the device one cycle later. If the spacing has not elapsed, the gate holds the request off. If the command does not fit the bank's state, the gate rejects it with an error flag and never issues it.

Every bank runs a two-state machine. `BK_CLOSED` moves to `BK_OPEN` on a granted ACTIVE, and `BK_OPEN` moves back to `BK_CLOSED` on a granted PRECHARGE. No other command moves a bank between states. Each bank owns down-counters for row cycle, minimum row-open time, precharge recovery, activate-to-access delay and write recovery. A row-age counter raises a per-bank force-precharge request shortly before the maximum row-open time expires. Three shared counters cover spacing between activates on different banks, spacing between column commands, and burst stop after a write. Nanosecond limits are parameters. They are turned into clock counts at elaboration by dividing by the clock period and rounding any fraction up.

Top module: `sdcg_top`

## Requirements
- R1: After reset, all banks are closed, `dev_cmd` is NOP (0), `force_pre` is all zeros, `req_err` is low and an ACTIVE request is ready at once.
- R2: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4 and BURST STOP=5. A request is granted when `req_valid`, `req_ready` and not `req_err` all hold at a rising edge. The granted code and bank appear on `dev_cmd` and `dev_bank` for exactly the cycle after that edge. In every other cycle `dev_cmd` is NOP.
- R3: Each nanosecond limit becomes ceil(limit_ps / CLK_PERIOD_PS) clocks. In the timing rules below, a spacing of N clocks means the second command is granted no earlier than N edges after the first.
- R4: READ or WRITE to a bank is held until RCD clocks after that bank's ACTIVE.
- R5: An ACTIVE is held until RRD clocks after the most recent ACTIVE to any bank.
- R6: PRECHARGE to a bank is held until RAS clocks after its ACTIVE and WR_CK clocks after its most recent WRITE. The data-in of a WRITE is taken in the WRITE cycle.
- R7: An ACTIVE to a bank is held until RP clocks after its PRECHARGE and RC clocks after its previous ACTIVE.
- R8: READ and WRITE commands to any banks are spaced by CCD_CK clocks. BURST STOP is held until BDL_CK clocks after the most recent WRITE. The bank field of BURST STOP is ignored.
- R9: The following requests raise `req_err` together with `req_ready` in the same cycle, issue nothing and leave the bank state unchanged: ACTIVE to an open bank, READ, WRITE or PRECHARGE to a closed bank, and any code other than 1 to 5.
- R10: `force_pre[i]` is high exactly while bank i is open and at least RAS_MAX − WARN_MARGIN_CK clocks have passed since its ACTIVE. It drops in the cycle after the bank is precharged.
- R11: While a legal request is held (`req_ready` low), `dev_cmd` stays NOP and no bank counter or state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BANK_W | Target bank |
| req_ready | output | 1 | Request accepted this cycle (granted or rejected) |
| req_err | output | 1 | Request rejected as illegal for bank state |
| dev_cmd | output | 3 | Command driven to the device |
| dev_bank | output | BANK_W | Bank of the driven command |
| force_pre | output | NUM_BANKS | Per-bank request to precharge soon |

## Verification
The bench runs at a clock period for which every nanosecond limit has a fractional quotient. A design that truncated instead of rounding up would therefore grant each held command one cycle early. The row-cycle limit is raised so that it outlasts minimum row-open time plus precharge recovery. This separates the row-cycle counter from the precharge recovery counter, and a design that checked only one of them would release the activate too soon. The write-recovery case puts the WRITE after the minimum row-open time has already passed, so a design that ignored write recovery would grant the PRECHARGE one cycle early. Illegal requests are followed by legal ones to the same bank, which shows whether a rejected command slipped through or changed bank state. The force-precharge flag is sampled on the cycle before and the cycle of its threshold, so an off-by-one in the age counter shows up.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5
    } cmd_e;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bank_st_e;

    function automatic int ps_to_ck(input int ps, input int period_ps);
        return (ps + period_ps - 1) / period_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int maxval);
        return (maxval < 1) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/sdcg_timer.sv
module sdcg_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         idle
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0);

    // R3
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !idle);

endmodule

// File: rtl/sdcg_bank.sv
module sdcg_bank
    import sdcg_pkg::*;
#(
    parameter int RC_CK     = 7,
    parameter int RAS_CK    = 5,
    parameter int RP_CK     = 2,
    parameter int RCD_CK    = 2,
    parameter int WR_CK     = 2,
    parameter int AGE_LIMIT = 9936
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_wr,
    input  logic do_pre,
    output logic is_open,
    output logic act_ok,
    output logic rw_ok,
    output logic pre_ok,
    output logic force_pre
);

    localparam int TMAX = max2(max2(max2(RC_CK, RAS_CK), max2(RP_CK, RCD_CK)), WR_CK);
    localparam int TW   = cnt_width(TMAX);
    localparam int AW   = cnt_width(AGE_LIMIT);

    bank_st_e st_q, st_d;
    logic     rc_idle, ras_idle, rp_idle, rcd_idle, wr_idle;
    logic [AW-1:0] age_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_CLOSED: if (do_act) st_d = BK_OPEN;
            BK_OPEN:   if (do_pre) st_d = BK_CLOSED;
            default:   st_d = BK_CLOSED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BK_CLOSED;
        else        st_q <= st_d;
    end

    // row age since activate, saturating at the warning threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (do_act) begin
            age_q <= '0;
        end else if (st_q == BK_OPEN && age_q != AW'(AGE_LIMIT)) begin
            age_q <= age_q + 1'b1;
        end
    end

    sdcg_timer #(.W(TW)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(do_act),
        .load_val(TW'(RC_CK - 1)), .idle(rc_idle));
    sdcg_timer #(.W(TW)) u_ras (
        .clk(clk), .rst_n(rst_n), .load(do_act),
        .load_val(TW'(RAS_CK - 1)), .idle(ras_idle));
    sdcg_timer #(.W(TW)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load(do_act),
        .load_val(TW'(RCD_CK - 1)), .idle(rcd_idle));
    sdcg_timer #(.W(TW)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(do_pre),
        .load_val(TW'(RP_CK - 1)), .idle(rp_idle));
    sdcg_timer #(.W(TW)) u_wr (
        .clk(clk), .rst_n(rst_n), .load(do_wr),
        .load_val(TW'(WR_CK - 1)), .idle(wr_idle));

    // outputs
    always_comb begin
        is_open   = (st_q == BK_OPEN);
        act_ok    = (st_q == BK_CLOSED) && rc_idle && rp_idle;
        rw_ok     = (st_q == BK_OPEN) && rcd_idle;
        pre_ok    = (st_q == BK_OPEN) && ras_idle && wr_idle;
        force_pre = (st_q == BK_OPEN) && (age_q == AW'(AGE_LIMIT));
    end

    // R9
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> st_q == BK_CLOSED);

    // R6
    pre_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |-> (ras_idle && wr_idle && st_q == BK_OPEN));

    // R7
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (rc_idle && rp_idle));

    // R10
    force_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |=> !force_pre);

endmodule

// File: rtl/sdcg_top.sv
module sdcg_top
    import sdcg_pkg::*;
#(
    parameter int NUM_BANKS      = 4,
    parameter int CLK_PERIOD_PS  = 10000,
    parameter int T_RC_PS        = 62000,
    parameter int T_RAS_PS       = 42000,
    parameter int T_RAS_MAX_PS   = 100000000,
    parameter int T_RP_PS        = 20000,
    parameter int T_RCD_PS       = 20000,
    parameter int T_RRD_PS       = 14000,
    parameter int CCD_CK         = 1,
    parameter int WR_CK          = 2,
    parameter int BDL_CK         = 1,
    parameter int WARN_MARGIN_CK = 64,
    localparam int BANK_W        = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_cmd,
    input  logic [BANK_W-1:0]    req_bank,
    output logic                 req_ready,
    output logic                 req_err,
    output logic [2:0]           dev_cmd,
    output logic [BANK_W-1:0]    dev_bank,
    output logic [NUM_BANKS-1:0] force_pre
);

    localparam int RC_CK   = ps_to_ck(T_RC_PS, CLK_PERIOD_PS);
    localparam int RAS_CK  = ps_to_ck(T_RAS_PS, CLK_PERIOD_PS);
    localparam int RMAX_CK = ps_to_ck(T_RAS_MAX_PS, CLK_PERIOD_PS);
    localparam int RP_CK   = ps_to_ck(T_RP_PS, CLK_PERIOD_PS);
    localparam int RCD_CK  = ps_to_ck(T_RCD_PS, CLK_PERIOD_PS);
    localparam int RRD_CK  = ps_to_ck(T_RRD_PS, CLK_PERIOD_PS);
    localparam int AGE_LIM = RMAX_CK - WARN_MARGIN_CK;
    localparam int XW      = cnt_width(max2(max2(RRD_CK, CCD_CK), BDL_CK));

    cmd_e req_op;
    logic legal, timing_ok, grant;
    logic rrd_idle, ccd_idle, bdl_idle;
    logic is_act, is_rw, is_wr, is_pre;
    logic [NUM_BANKS-1:0] open_v, act_ok_v, rw_ok_v, pre_ok_v;
    cmd_e dev_cmd_q;
    logic [BANK_W-1:0] dev_bank_q;

    assign req_op = cmd_e'(req_cmd);

    // legality and spacing decode for the addressed bank
    always_comb begin
        legal     = 1'b0;
        timing_ok = 1'b0;
        unique case (req_op)
            CMD_ACT: begin
                legal     = !open_v[req_bank];
                timing_ok = act_ok_v[req_bank] && rrd_idle;
            end
            CMD_RD, CMD_WR: begin
                legal     = open_v[req_bank];
                timing_ok = rw_ok_v[req_bank] && ccd_idle;
            end
            CMD_PRE: begin
                legal     = open_v[req_bank];
                timing_ok = pre_ok_v[req_bank];
            end
            CMD_BST: begin
                legal     = 1'b1;
                timing_ok = bdl_idle;
            end
            default: begin
                legal     = 1'b0;
                timing_ok = 1'b0;
            end
        endcase
    end

    assign req_ready = !legal || timing_ok;
    assign req_err   = req_valid && !legal;
    assign grant     = req_valid && legal && timing_ok;

    assign is_act = grant && (req_op == CMD_ACT);
    assign is_rw  = grant && (req_op == CMD_RD || req_op == CMD_WR);
    assign is_wr  = grant && (req_op == CMD_WR);
    assign is_pre = grant && (req_op == CMD_PRE);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic sel;
            assign sel = (req_bank == BANK_W'(b));
            sdcg_bank #(
                .RC_CK(RC_CK), .RAS_CK(RAS_CK), .RP_CK(RP_CK),
                .RCD_CK(RCD_CK), .WR_CK(WR_CK), .AGE_LIMIT(AGE_LIM)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .do_act    (is_act && sel),
                .do_wr     (is_wr && sel),
                .do_pre    (is_pre && sel),
                .is_open   (open_v[b]),
                .act_ok    (act_ok_v[b]),
                .rw_ok     (rw_ok_v[b]),
                .pre_ok    (pre_ok_v[b]),
                .force_pre (force_pre[b])
            );
        end
    endgenerate

    sdcg_timer #(.W(XW)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(is_act),
        .load_val(XW'(RRD_CK - 1)), .idle(rrd_idle));
    sdcg_timer #(.W(XW)) u_ccd (
        .clk(clk), .rst_n(rst_n), .load(is_rw),
        .load_val(XW'(CCD_CK - 1)), .idle(ccd_idle));
    sdcg_timer #(.W(XW)) u_bdl (
        .clk(clk), .rst_n(rst_n), .load(is_wr),
        .load_val(XW'(BDL_CK - 1)), .idle(bdl_idle));

    // device command register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_cmd_q  <= CMD_NOP;
            dev_bank_q <= '0;
        end else if (grant) begin
            dev_cmd_q  <= req_op;
            dev_bank_q <= req_bank;
        end else begin
            dev_cmd_q  <= CMD_NOP;
            dev_bank_q <= '0;
        end
    end

    assign dev_cmd  = dev_cmd_q;
    assign dev_bank = dev_bank_q;

    // R2
    issue_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_err) |=> (dev_cmd == $past(req_cmd)));

    // R9
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> (dev_cmd == 3'd0));

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (dev_cmd == 3'd0));

    // R5
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_cmd == 3'd1 && RRD_CK > 1) |=> (dev_cmd != 3'd1));

endmodule

// File: tb/sdcg_top_tb.sv
module sdcg_top_tb;

    localparam int CLK_PER = 10;
    localparam int PER_PS  = 7500;
    localparam int RC_PS   = 80000;
    localparam int MARGIN  = 64;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    localparam int E_RC   = cdiv(RC_PS, PER_PS);
    localparam int E_RAS  = cdiv(42000, PER_PS);
    localparam int E_RP   = cdiv(20000, PER_PS);
    localparam int E_RCD  = cdiv(20000, PER_PS);
    localparam int E_RRD  = cdiv(14000, PER_PS);
    localparam int E_LIM  = cdiv(100000000, PER_PS) - MARGIN;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd1;
    logic [1:0] req_bank = 2'd0;
    logic       req_ready, req_err;
    logic [2:0] dev_cmd;
    logic [1:0] dev_bank;
    logic [3:0] force_pre;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int   w_cnt;
    bit   e_flag;
    logic [2:0] o_cmd;
    logic [1:0] o_bank;
    bit   hold_bad;

    always #(CLK_PER / 2) clk = ~clk;

    sdcg_top #(
        .CLK_PERIOD_PS(PER_PS), .T_RC_PS(RC_PS), .WARN_MARGIN_CK(MARGIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_ready(req_ready), .req_err(req_err),
        .dev_cmd(dev_cmd), .dev_bank(dev_bank), .force_pre(force_pre)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // starts and ends at a negedge; counts cycles held off
    task automatic issue(input logic [2:0] c, input logic [1:0] b);
        req_valid = 1'b1;
        req_cmd   = c;
        req_bank  = b;
        w_cnt     = 0;
        hold_bad  = 1'b0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            if (dev_cmd != 3'd0) hold_bad = 1'b1;
            w_cnt++;
            #1;
        end
        e_flag = req_err;
        @(negedge clk);
        o_cmd  = dev_cmd;
        o_bank = dev_bank;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        req_cmd = 3'd1; req_bank = 2'd0;
        #1;
        chk(dev_cmd == 3'd0, "R1 dev_cmd", dev_cmd, 0);
        chk(force_pre == 4'd0, "R1 force_pre", force_pre, 0);
        chk(req_ready == 1'b1 && req_err == 1'b0, "R1 ready", req_ready, 1);
    endtask

    task automatic t_rcd();
        do_reset();
        issue(3'd1, 2'd0);
        chk(w_cnt == 0 && o_cmd == 3'd1 && o_bank == 2'd0, "R2 act issue", o_cmd, 1);
        issue(3'd2, 2'd0);
        chk(w_cnt == E_RCD - 1, "R4 rcd wait", w_cnt, E_RCD - 1);
        chk(!hold_bad, "R11 nop while held", hold_bad, 0);
        chk(o_cmd == 3'd2, "R2 read issue", o_cmd, 2);
    endtask

    task automatic t_rrd();
        do_reset();
        issue(3'd1, 2'd0);
        issue(3'd1, 2'd1);
        chk(w_cnt == E_RRD - 1 && o_bank == 2'd1, "R5 rrd wait", w_cnt, E_RRD - 1);
        issue(3'd1, 2'd2);
        chk(w_cnt == E_RRD - 1 && o_bank == 2'd2, "R5 rrd wait b2", w_cnt, E_RRD - 1);
    endtask

    task automatic t_ras_rc();
        do_reset();
        issue(3'd1, 2'd0);
        issue(3'd4, 2'd0);
        chk(w_cnt == E_RAS - 1 && o_cmd == 3'd4, "R6 ras wait", w_cnt, E_RAS - 1);
        issue(3'd1, 2'd0);
        chk(w_cnt == E_RC - E_RAS - 1, "R7 rc wait", w_cnt, E_RC - E_RAS - 1);
        chk(!hold_bad, "R11 nop while held rc", hold_bad, 0);
    endtask

    task automatic t_rp();
        do_reset();
        issue(3'd1, 2'd3);
        idle(E_RC - 1);
        issue(3'd4, 2'd3);
        chk(w_cnt == 0, "R6 pre after rc", w_cnt, 0);
        issue(3'd1, 2'd3);
        chk(w_cnt == E_RP - 1, "R7 rp wait", w_cnt, E_RP - 1);
    endtask

    task automatic t_wr();
        do_reset();
        issue(3'd1, 2'd0);
        idle(E_RAS - 1);
        issue(3'd3, 2'd0);
        chk(w_cnt == 0 && o_cmd == 3'd3, "R2 write issue", o_cmd, 3);
        issue(3'd4, 2'd0);
        chk(w_cnt == 1, "R6 write recovery wait", w_cnt, 1);
    endtask

    task automatic t_ccd_bst();
        do_reset();
        issue(3'd1, 2'd1);
        issue(3'd2, 2'd1);
        issue(3'd2, 2'd1);
        chk(w_cnt == 0 && o_cmd == 3'd2, "R8 read-read gap", w_cnt, 0);
        issue(3'd3, 2'd1);
        chk(w_cnt == 0 && o_cmd == 3'd3, "R8 read-write gap", w_cnt, 0);
        issue(3'd5, 2'd2);
        chk(w_cnt == 0 && o_cmd == 3'd5 && !e_flag, "R8 bst after write", o_cmd, 5);
        idle(1);
        chk(dev_cmd == 3'd0, "R2 nop when idle", dev_cmd, 0);
    endtask

    task automatic t_errors();
        do_reset();
        issue(3'd2, 2'd3);
        chk(e_flag && w_cnt == 0 && o_cmd == 3'd0, "R9 read closed", o_cmd, 0);
        issue(3'd4, 2'd1);
        chk(e_flag && o_cmd == 3'd0, "R9 pre closed", e_flag, 1);
        issue(3'd7, 2'd0);
        chk(e_flag && o_cmd == 3'd0, "R9 bad code", e_flag, 1);
        issue(3'd1, 2'd3);
        chk(!e_flag && o_cmd == 3'd1, "R9 act after reject", o_cmd, 1);
        issue(3'd1, 2'd3);
        chk(e_flag && o_cmd == 3'd0, "R9 act open", o_cmd, 0);
        issue(3'd2, 2'd3);
        chk(!e_flag && o_cmd == 3'd2, "R9 state kept open", o_cmd, 2);
    endtask

    task automatic t_force();
        do_reset();
        issue(3'd1, 2'd2);
        idle(E_LIM - 1);
        chk(force_pre == 4'd0, "R10 before limit", force_pre, 0);
        idle(1);
        chk(force_pre == 4'b0100, "R10 at limit", force_pre, 4);
        issue(3'd4, 2'd2);
        chk(force_pre == 4'd0 && o_cmd == 3'd4, "R10 cleared by pre", force_pre, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rcd();
        t_rrd();
        t_ras_rc();
        t_rp();
        t_wr();
        t_ccd_bst();
        t_errors();
        t_force();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule